// File: doc/BRIEF.md
# Overlapping 1-0-1 Serial Pattern Detector

This block watches a single serial bit stream and raises a one-bit flag whenever the three most recent samples read 1, 0, 1. It samples the input on each rising clock edge. Upstream logic is expected to change the input only near falling edges. The flag is a Moore output: it depends only on the registered state, so it changes just after a rising edge and holds for one full clock period.

Instead of keeping the last three bits and comparing them, the block tracks how much of the pattern it has matched so far. It uses four states in a two-bit register: idle, one seen, one-zero seen and full match. Matches may overlap. The final 1 of a match also counts as the first 1 of the next one, so the stream 1,0,1,0,1 flags twice. A synchronous, active-high reset returns the machine to idle.

Top module: `seqdet_101`

## Requirements
- R1: When `rst` is high at a rising edge, the machine goes to idle and `hit` is low after that edge, whatever the value of `din`.
- R2: `hit` is high after the rising edge that samples the final 1 of three consecutive samples 1, 0, 1 taken with `rst` low. It is low after every other edge.
- R3: `hit` is never high for two consecutive clock periods.
- R4: Overlap is honoured. After a match, a 0 followed by a 1 produces a second match, so 1,0,1,0,1 raises `hit` twice.
- R5: A run of several 1s keeps only the latest 1 as a partial match, so 1,1,0,1 raises `hit` on the last sample.
- R6: Two 0s in a row discard any partial match, so 1,0,0,1 raises no `hit`. A later 0,1 completes a fresh match only after a new leading 1.
- R7: A reset in the middle of a partial match clears it. After 1,0, a reset, then 1, `hit` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `din` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| din | input | 1 | Serial data bit |
| hit | output | 1 | High for one period after the 1,0,1 pattern completes |

## Verification
The assertions assume that `din` and `rst` are stable around each rising edge and that `rst` is high at the first edge, so the state is known before any property is enabled. The bench meets this by driving both inputs only on falling edges. It holds reset from time zero and samples `hit` a quarter period after each rising edge. The history-based properties look back three edges, which a reset-started run always provides before the first flag can appear.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 2;

  // Partial-match progress: low bit = last sample was 1.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 2'b00,
    ST_ONE     = 2'b01,
    ST_ONEZERO = 2'b10,
    ST_HIT     = 2'b11
  } match_state_e;

  function automatic match_state_e step_state(match_state_e cur, logic bit_in);
    logic [STATE_W-1:0] c;
    logic [STATE_W-1:0] n;
    c    = cur;
    n[1] = (c[0] & ~bit_in) | (c[1] & ~c[0] & bit_in);
    n[0] = bit_in;
    return match_state_e'(n);
  endfunction

  function automatic logic is_match(match_state_e cur);
    logic [STATE_W-1:0] c;
    c = cur;
    return c[1] & c[0];
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  match_state_e cur_i,
  input  logic         bit_i,
  output match_state_e nxt_o
);
  always_comb nxt_o = step_state(cur_i, bit_i);
endmodule

// File: rtl/seqdet_decode.sv
module seqdet_decode
  import seqdet_pkg::*;
(
  input  match_state_e cur_i,
  output logic         hit_o
);
  always_comb hit_o = is_match(cur_i);
endmodule

// File: rtl/seqdet_101.sv
module seqdet_101
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  match_state_e state_q;
  match_state_e state_d;
  logic         hit_w;

  seqdet_next u_next (
    .cur_i (state_q),
    .bit_i (din),
    .nxt_o (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  seqdet_decode u_decode (
    .cur_i (state_q),
    .hit_o (hit_w)
  );

  assign hit = hit_w;

  // R1: reset lands in idle with the flag low
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE) && !hit);

  // R2: a flag is always backed by the samples 1,0,1
  a_r2_hit_needs_101: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(din, 1) && !$past(din, 2) && $past(din, 3)));

  // R3: single-period pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  // R4: trailing 1 of a match seeds the next match
  a_r4_overlap_seed: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HIT && din) |=> state_q == ST_ONE);

  a_r4_overlap_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HIT && !din) |=> state_q == ST_ONEZERO);

  // R5: repeated 1s hold the one-seen state
  a_r5_ones_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONE && din) |=> state_q == ST_ONE);

  // R6: 1,0 followed by 0 drops back to idle
  a_r6_double_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONEZERO && !din) |=> state_q == ST_IDLE);

endmodule

// File: tb/seqdet_101_bench.sv
module seqdet_101_bench;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  // Reference model: history of valid samples since reset.
  logic [2:0] hist = 3'b000;
  int         valid_cnt = 0;
  logic       prev_hit = 1'b0;

  seqdet_101 u_seqdet_101 (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic send(input logic b, input logic r, input string tag);
    logic e;
    @(negedge clk);
    din = b;
    rst = r;
    if (r) begin
      valid_cnt = 0;
      e = 1'b0;
    end else begin
      hist = {hist[1:0], b};
      if (valid_cnt < 3) valid_cnt++;
      e = (valid_cnt == 3) && (hist == 3'b101);
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) send(bits[i], 1'b0, tag);
  endtask

  // Monitor: compares one queued item per rising edge.
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (hit !== e) begin
        errors++;
        $display("FAIL %s: hit=%b expected=%b at %0t", t, hit, e, $time);
      end
      checks++;
      if (prev_hit === 1'b1 && hit === 1'b1) begin
        errors++;
        $display("FAIL R3: hit=%b expected=0 after a flagged period at %0t", hit, $time);
      end
      prev_hit = hit;
    end
  end

  initial begin
    logic [7:0] lfsr;
    send(1'b1, 1'b1, "R1");
    send(1'b1, 1'b1, "R1");
    send_bits(16'b101, 3, "R2");
    send(1'b0, 1'b0, "R2 R3");
    send(1'b1, 1'b0, "R4");
    send_bits(16'b0101, 4, "R4");
    send(1'b0, 1'b1, "R1");
    send_bits(16'b1101, 4, "R5");
    send(1'b1, 1'b1, "R1");
    send_bits(16'b1001, 4, "R6");
    send_bits(16'b0101, 4, "R6");
    send(1'b1, 1'b1, "R1");
    send_bits(16'b10, 2, "R7");
    send(1'b1, 1'b1, "R7");
    send_bits(16'b01, 2, "R7");
    send_bits(16'b01, 2, "R7");
    lfsr = 8'hA5;
    for (int k = 0; k < 300; k++) begin
      send(lfsr[0], 1'b0, "R2 R3");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    send(1'b0, 1'b0, "R2");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 2);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule